// File: doc/BRIEF.md
# Accumulate, Round, Window and Clamp Output Stage

This block is the back end of a multi-tap filter datapath. Each clock it takes one signed 32-bit sum of products from the multiplier array. It either starts a new running total with that value or adds the value to the total it already holds. A programmable offset is then added to the 32-bit total. The offset comes from one of sixteen rounding registers. A 16-bit slice of the offset total is picked by a shift code. The slice can be clamped between a signed upper and lower bound, taken from one of sixteen bound registers. The final value lands in an output register that loads only when its active-low enable is asserted.

The two register banks are filled through a simple write port driven by a separate loader. Every per-sample control (accumulate, shift code, round select, bound select, bound enable and output enable) is sampled together with its sum of products. Each control then travels down the pipeline with that sample. A stream can therefore change its settings on any cycle without mixing them between samples.

Top module: `acc_rnd_lim_stage`

## Requirements
- R1: When `acc_en_i` is 0, the accumulator discards its old total and takes `sop_i` as its new value.
- R2: When `acc_en_i` is 1, `sop_i` is added to the held total, with wraparound modulo 2^32.
- R3: The 32-bit rounding register picked by `rnd_sel_i` is added to the accumulator value, with wraparound modulo 2^32.
- R4: For a shift code s from 0 to 16, the windowed value is bits [s+15:s] of the rounded 32-bit value.
- R5: Shift codes 17 to 31 act as code 16 and select bits [31:16].
- R6: When `lim_en_n_i` is 0, the window is clamped using the bound register picked by `lim_sel_i`. Bits [31:16] of that register are the signed upper bound and bits [15:0] are the signed lower bound. A value above the upper bound becomes the upper bound. Otherwise, a value below the lower bound becomes the lower bound.
- R7: When `lim_en_n_i` is 1, the windowed value passes the clamp unchanged.
- R8: When `out_en_n_i` is 0, the output register loads the stage result. When it is 1, `result_o` keeps its previous value.
- R9: A sample and its controls presented before rising edge k appear on `result_o` right after rising edge k+4. There are five register stages and a new sample is accepted every cycle.
- R10: When `cfg_we_i` is 1, `cfg_data_i` is written on the clock edge to entry `cfg_addr_i`. The target bank is rounding if `cfg_bank_i` is 0 and bound if it is 1. A sample presented in the next cycle already uses the new value.
- R11: Reset sets the accumulator, the output register and every entry of both banks to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sop_i | input | 32 | Signed sum of products for this cycle |
| acc_en_i | input | 1 | 1 adds to the running total, 0 restarts it |
| shift_i | input | 5 | Window position code |
| rnd_sel_i | input | 4 | Rounding register select |
| lim_sel_i | input | 4 | Bound register select |
| lim_en_n_i | input | 1 | Active-low clamp enable |
| out_en_n_i | input | 1 | Active-low output register load enable |
| cfg_we_i | input | 1 | Bank write strobe |
| cfg_bank_i | input | 1 | Bank choice: 0 rounding, 1 bound |
| cfg_addr_i | input | 4 | Entry index for the write |
| cfg_data_i | input | 32 | Write data |
| result_o | output | 16 | Registered stage result |

## Verification
The bench targets these cases:
- Accumulator wraparound past the largest positive total. A design with a wider or saturating sum shows a different upper window.
- A rounding offset that carries into the selected window. A design that rounds after slicing loses the carry.
- Shift codes above 16. A design that does not saturate them returns wrapped or zero-filled bits.
- Values on both sides of each bound. A design that compares unsigned would let negative values through the clamp or clamp them wrongly.
- Output enable deasserted between two samples. The held value must stay, and a design that ignores the enable shows the newer sample.
- A bank write followed at once by a sample that uses it. This exposes a late write path.

// File: rtl/arls_pkg.sv
package arls_pkg;

    localparam int ACC_W   = 32;
    localparam int OUT_W   = 16;
    localparam int SEL_W   = 4;
    localparam int SHF_W   = 5;
    localparam int NREG    = 1 << SEL_W;

    // controls captured with the sample
    typedef struct packed {
        logic [SHF_W-1:0] shift;
        logic [SEL_W-1:0] rnd_sel;
        logic [SEL_W-1:0] lim_sel;
        logic             lim_en_n;
        logic             oe_n;
    } ctl_t;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        ctl_t             ctl;
    } st_acc_t;

    typedef struct packed {
        logic [ACC_W-1:0] rnd;
        logic [SHF_W-1:0] shift;
        logic [SEL_W-1:0] lim_sel;
        logic             lim_en_n;
        logic             oe_n;
    } st_rnd_t;

    typedef struct packed {
        logic [OUT_W-1:0] win;
        logic [SEL_W-1:0] lim_sel;
        logic             lim_en_n;
        logic             oe_n;
    } st_win_t;

    typedef struct packed {
        logic [OUT_W-1:0] lim;
        logic             oe_n;
    } st_lim_t;

    typedef struct packed {
        st_acc_t          s1;
        st_rnd_t          s2;
        st_win_t          s3;
        st_lim_t          s4;
        logic [OUT_W-1:0] out;
    } pipe_t;

endpackage

// File: rtl/arls_regbank.sv
module arls_regbank #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [W-1:0]  rdata_o
);

    logic [DEPTH-1:0][W-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we_i) begin
            bank_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rdata_o = bank_q[raddr_i];

endmodule

// File: rtl/arls_window.sv
module arls_window #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 16,
    parameter int SH_W  = 5
) (
    input  logic [IN_W-1:0]  data_i,
    input  logic [SH_W-1:0]  shift_i,
    output logic [OUT_W-1:0] win_o
);

    localparam int MAX_SH = IN_W - OUT_W;

    logic [MAX_SH:0][OUT_W-1:0] cand;

    for (genvar k = 0; k <= MAX_SH; k++) begin : g_cand
        assign cand[k] = data_i[k+OUT_W-1:k];
    end

    always_comb begin
        win_o = cand[MAX_SH];
        for (int k = 0; k < MAX_SH; k++) begin
            if (int'(shift_i) == k) begin
                win_o = cand[k];
            end
        end
    end

endmodule

// File: rtl/arls_clamp.sv
module arls_clamp #(
    parameter int W = 16
) (
    input  logic [W-1:0]   val_i,
    input  logic [2*W-1:0] bounds_i,
    input  logic           en_n_i,
    output logic [W-1:0]   val_o
);

    logic signed [W-1:0] upper, lower, v;

    always_comb begin
        upper = bounds_i[2*W-1:W];
        lower = bounds_i[W-1:0];
        v     = val_i;
        val_o = val_i;
        if (!en_n_i) begin
            if (v > upper) begin
                val_o = upper;
            end else if (v < lower) begin
                val_o = lower;
            end
        end
    end

endmodule

// File: rtl/acc_rnd_lim_stage.sv
module acc_rnd_lim_stage
    import arls_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] sop_i,
    input  logic             acc_en_i,
    input  logic [SHF_W-1:0] shift_i,
    input  logic [SEL_W-1:0] rnd_sel_i,
    input  logic [SEL_W-1:0] lim_sel_i,
    input  logic             lim_en_n_i,
    input  logic             out_en_n_i,
    input  logic             cfg_we_i,
    input  logic             cfg_bank_i,
    input  logic [SEL_W-1:0] cfg_addr_i,
    input  logic [ACC_W-1:0] cfg_data_i,
    output logic [OUT_W-1:0] result_o
);

    pipe_t pipe_d, pipe_q;

    logic [ACC_W-1:0]   rnd_word;
    logic [2*OUT_W-1:0] lim_word;
    logic [OUT_W-1:0]   win_val;
    logic [OUT_W-1:0]   clamp_val;
    logic               we_rnd, we_lim;

    assign we_rnd = cfg_we_i && !cfg_bank_i;
    assign we_lim = cfg_we_i &&  cfg_bank_i;

    arls_regbank #(.W(ACC_W), .DEPTH(NREG)) u_rnd_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we_rnd),
        .waddr_i (cfg_addr_i),
        .wdata_i (cfg_data_i),
        .raddr_i (pipe_q.s1.ctl.rnd_sel),
        .rdata_o (rnd_word)
    );

    arls_regbank #(.W(2*OUT_W), .DEPTH(NREG)) u_lim_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we_lim),
        .waddr_i (cfg_addr_i),
        .wdata_i (cfg_data_i[2*OUT_W-1:0]),
        .raddr_i (pipe_q.s3.lim_sel),
        .rdata_o (lim_word)
    );

    arls_window #(.IN_W(ACC_W), .OUT_W(OUT_W), .SH_W(SHF_W)) u_window (
        .data_i  (pipe_q.s2.rnd),
        .shift_i (pipe_q.s2.shift),
        .win_o   (win_val)
    );

    arls_clamp #(.W(OUT_W)) u_clamp (
        .val_i    (pipe_q.s3.win),
        .bounds_i (lim_word),
        .en_n_i   (pipe_q.s3.lim_en_n),
        .val_o    (clamp_val)
    );

    always_comb begin
        pipe_d = pipe_q;

        // stage 1: accumulate or restart
        pipe_d.s1.acc          = acc_en_i ? (pipe_q.s1.acc + sop_i) : sop_i;
        pipe_d.s1.ctl.shift    = shift_i;
        pipe_d.s1.ctl.rnd_sel  = rnd_sel_i;
        pipe_d.s1.ctl.lim_sel  = lim_sel_i;
        pipe_d.s1.ctl.lim_en_n = lim_en_n_i;
        pipe_d.s1.ctl.oe_n     = out_en_n_i;

        // stage 2: add offset
        pipe_d.s2.rnd      = pipe_q.s1.acc + rnd_word;
        pipe_d.s2.shift    = pipe_q.s1.ctl.shift;
        pipe_d.s2.lim_sel  = pipe_q.s1.ctl.lim_sel;
        pipe_d.s2.lim_en_n = pipe_q.s1.ctl.lim_en_n;
        pipe_d.s2.oe_n     = pipe_q.s1.ctl.oe_n;

        // stage 3: window
        pipe_d.s3.win      = win_val;
        pipe_d.s3.lim_sel  = pipe_q.s2.lim_sel;
        pipe_d.s3.lim_en_n = pipe_q.s2.lim_en_n;
        pipe_d.s3.oe_n     = pipe_q.s2.oe_n;

        // stage 4: clamp
        pipe_d.s4.lim  = clamp_val;
        pipe_d.s4.oe_n = pipe_q.s3.oe_n;

        // stage 5: output register
        if (!pipe_q.s4.oe_n) begin
            pipe_d.out = pipe_q.s4.lim;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign result_o = pipe_q.out;

endmodule

// File: rtl/arls_checker.sv
module arls_checker #(
    parameter int ACC_W = 32,
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ACC_W-1:0] sop_i,
    input logic             acc_en_i,
    input logic [ACC_W-1:0] acc_q,
    input logic [ACC_W-1:0] rnd_q,
    input logic [4:0]       shift_q,
    input logic [OUT_W-1:0] win_q,
    input logic             lim_en_n_q,
    input logic [2*OUT_W-1:0] bounds,
    input logic [OUT_W-1:0] lim_q,
    input logic             oe_n_q,
    input logic [OUT_W-1:0] result_o
);

    p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!acc_en_i) |-> (acc_q == $past(sop_i)));

    p_window_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(shift_q >= 5'd16) |-> (win_q == $past(rnd_q[ACC_W-1:ACC_W-OUT_W])));

    p_clamp_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!lim_en_n_q && ($signed(bounds[2*OUT_W-1:OUT_W]) >= $signed(bounds[OUT_W-1:0])))
        |-> (($signed(lim_q) <= $signed($past(bounds[2*OUT_W-1:OUT_W]))) &&
             ($signed(lim_q) >= $signed($past(bounds[OUT_W-1:0])))));

    p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lim_en_n_q) |-> (lim_q == $past(win_q)));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(oe_n_q) |-> $stable(result_o));

endmodule

bind acc_rnd_lim_stage arls_checker #(.ACC_W(arls_pkg::ACC_W), .OUT_W(arls_pkg::OUT_W)) u_arls_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sop_i      (sop_i),
    .acc_en_i   (acc_en_i),
    .acc_q      (pipe_q.s1.acc),
    .rnd_q      (pipe_q.s2.rnd),
    .shift_q    (pipe_q.s2.shift),
    .win_q      (pipe_q.s3.win),
    .lim_en_n_q (pipe_q.s3.lim_en_n),
    .bounds     (lim_word),
    .lim_q      (pipe_q.s4.lim),
    .oe_n_q     (pipe_q.s4.oe_n),
    .result_o   (result_o)
);

// File: tb/acc_rnd_lim_stage_tb.sv
module acc_rnd_lim_stage_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] sop_i = '0;
    logic        acc_en_i = 1'b0;
    logic [4:0]  shift_i = '0;
    logic [3:0]  rnd_sel_i = '0;
    logic [3:0]  lim_sel_i = '0;
    logic        lim_en_n_i = 1'b1;
    logic        out_en_n_i = 1'b1;
    logic        cfg_we_i = 1'b0;
    logic        cfg_bank_i = 1'b0;
    logic [3:0]  cfg_addr_i = '0;
    logic [31:0] cfg_data_i = '0;
    logic [15:0] result_o;

    always #2 clk = ~clk;

    acc_rnd_lim_stage dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sop_i      (sop_i),
        .acc_en_i   (acc_en_i),
        .shift_i    (shift_i),
        .rnd_sel_i  (rnd_sel_i),
        .lim_sel_i  (lim_sel_i),
        .lim_en_n_i (lim_en_n_i),
        .out_en_n_i (out_en_n_i),
        .cfg_we_i   (cfg_we_i),
        .cfg_bank_i (cfg_bank_i),
        .cfg_addr_i (cfg_addr_i),
        .cfg_data_i (cfg_data_i),
        .result_o   (result_o)
    );

    typedef struct {
        logic [15:0] exp;
        int          due;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    int          total = 0;
    int          bad = 0;
    int          cyc = 0;

    // reference state
    logic [31:0] m_acc = '0;
    logic [15:0] m_out = '0;
    logic [31:0] m_rnd [16];
    logic [31:0] m_lim [16];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic [31:0] sop, input logic acc,
                         input logic [4:0] sh, input logic [3:0] rs, input logic [3:0] ls,
                         input logic len_n, input logic oe_n);
        logic [31:0]        r;
        logic signed [15:0] w, ub, lb;
        int                 s;
        item_t              it;
        @(negedge clk);
        sop_i = sop; acc_en_i = acc; shift_i = sh; rnd_sel_i = rs;
        lim_sel_i = ls; lim_en_n_i = len_n; out_en_n_i = oe_n;
        m_acc = acc ? (m_acc + sop) : sop;
        r = m_acc + m_rnd[rs];
        s = (int'(sh) > 16) ? 16 : int'(sh);
        w = 16'(r >> s);
        if (!len_n) begin
            ub = m_lim[ls][31:16];
            lb = m_lim[ls][15:0];
            if (w > ub) w = ub;
            else if (w < lb) w = lb;
        end
        if (!oe_n) m_out = w;
        it.exp = m_out; it.due = cyc + 5; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic cfg_write(input logic bank, input logic [3:0] addr, input logic [31:0] data);
        cfg_we_i = 1'b1; cfg_bank_i = bank; cfg_addr_i = addr; cfg_data_i = data;
        drive("R8 idle hold", 32'd0, 1'b0, 5'd0, 4'd0, 4'd0, 1'b1, 1'b1);
        if (bank) m_lim[addr] = data;
        else      m_rnd[addr] = data;
        @(negedge clk);
        cfg_we_i = 1'b0;
        @(posedge clk);
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, result_o, it.exp);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_rnd[i] = '0;
            m_lim[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset output", result_o, 16'h0000);
        rst_n = 1'b1;

        // banks cleared by reset: offset 7 is zero
        drive("R11 bank zero", 32'd1234, 1'b0, 5'd0, 4'd7, 4'd0, 1'b1, 1'b0);
        drive("R1 restart", 32'h0000_1234, 1'b0, 5'd0, 4'd0, 4'd0, 1'b1, 1'b0);
        repeat (5) drive("R8 drain hold", 32'd0, 1'b0, 5'd0, 4'd0, 4'd0, 1'b1, 1'b1);

        cfg_write(1'b0, 4'd1, 32'h0000_8000);
        cfg_write(1'b0, 4'd2, 32'hFFFF_FFFB);
        cfg_write(1'b1, 4'd3, {16'sd100, -16'sd100});

        // accumulate, including negatives
        drive("R2 acc start", 32'd100, 1'b0, 5'd0, 4'd0, 4'd0, 1'b1, 1'b0);
        drive("R2 acc add", 32'd200, 1'b1, 5'd0, 4'd0, 4'd0, 1'b1, 1'b0);
        drive("R2 acc add", 32'd300, 1'b1, 5'd0, 4'd0, 4'd0, 1'b1, 1'b0);
        drive("R2 acc negative", -32'sd1000, 1'b1, 5'd0, 4'd0, 4'd0, 1'b1, 1'b0);
        drive("R1 restart after acc", 32'd55, 1'b0, 5'd0, 4'd0, 4'd0, 1'b1, 1'b0);
        // wraparound
        drive("R2 wrap base", 32'h7FFF_FFFF, 1'b0, 5'd16, 4'd0, 4'd0, 1'b1, 1'b0);
        drive("R2 wrap", 32'd1, 1'b1, 5'd16, 4'd0, 4'd0, 1'b1, 1'b0);
        // rounding carries into window
        drive("R3 round no carry", 32'h0001_7FFF, 1'b0, 5'd16, 4'd1, 4'd0, 1'b1, 1'b0);
        drive("R3 round carry", 32'h0001_8000, 1'b0, 5'd16, 4'd1, 4'd0, 1'b1, 1'b0);
        drive("R3 negative offset", 32'd10, 1'b0, 5'd0, 4'd2, 4'd0, 1'b1, 1'b0);
        // windows
        drive("R4 shift 8", 32'h1234_5678, 1'b0, 5'd8, 4'd0, 4'd0, 1'b1, 1'b0);
        drive("R4 shift 4", 32'h1234_5678, 1'b0, 5'd4, 4'd0, 4'd0, 1'b1, 1'b0);
        drive("R4 shift 16", 32'h1234_5678, 1'b0, 5'd16, 4'd0, 4'd0, 1'b1, 1'b0);
        drive("R5 shift 17", 32'h1234_5678, 1'b0, 5'd17, 4'd0, 4'd0, 1'b1, 1'b0);
        drive("R5 shift 31", 32'hABCD_5678, 1'b0, 5'd31, 4'd0, 4'd0, 1'b1, 1'b0);
        // clamp
        drive("R6 above upper", 32'd500, 1'b0, 5'd0, 4'd0, 4'd3, 1'b0, 1'b0);
        drive("R6 below lower", -32'sd500, 1'b0, 5'd0, 4'd0, 4'd3, 1'b0, 1'b0);
        drive("R6 inside", 32'd42, 1'b0, 5'd0, 4'd0, 4'd3, 1'b0, 1'b0);
        drive("R6 negative inside", -32'sd99, 1'b0, 5'd0, 4'd0, 4'd3, 1'b0, 1'b0);
        drive("R7 bypass", 32'd500, 1'b0, 5'd0, 4'd0, 4'd3, 1'b1, 1'b0);
        drive("R7 bypass negative", -32'sd500, 1'b0, 5'd0, 4'd0, 4'd3, 1'b1, 1'b0);
        // output enable
        drive("R8 load", 32'd777, 1'b0, 5'd0, 4'd0, 4'd0, 1'b1, 1'b0);
        drive("R8 hold", 32'd888, 1'b0, 5'd0, 4'd0, 4'd0, 1'b1, 1'b1);
        drive("R8 hold again", 32'd999, 1'b1, 5'd0, 4'd0, 4'd0, 1'b1, 1'b1);
        drive("R8 reload", 32'd321, 1'b0, 5'd0, 4'd0, 4'd0, 1'b1, 1'b0);
        repeat (5) drive("R9 drain", 32'd0, 1'b0, 5'd0, 4'd0, 4'd0, 1'b1, 1'b1);

        // write then use at once
        cfg_write(1'b0, 4'd4, 32'h0000_0080);
        drive("R10 new offset", 32'd0, 1'b0, 5'd0, 4'd4, 4'd0, 1'b1, 1'b0);
        cfg_write(1'b1, 4'd5, {16'sd20, 16'sd10});
        drive("R10 new bound low", 32'd3, 1'b0, 5'd0, 4'd0, 4'd5, 1'b0, 1'b0);
        drive("R9 back to back", 32'd15, 1'b0, 5'd0, 4'd0, 4'd5, 1'b0, 1'b0);
        drive("R9 back to back", 32'd30, 1'b0, 5'd0, 4'd0, 4'd5, 1'b0, 1'b0);

        repeat (10) @(negedge clk);
        if (sb_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R9: got %0d pending expected 0", sb_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule